// File: doc/BRIEF.md
# Control-Word Strobe Sequencer

This block runs a short program of 32-bit control words held in an external word array and turns each word into waveforms on four general-purpose strobe lines. Each word lasts four clock cycles, one per quarter phase T1, T2, T3 and T4. At the start of T1 and again at the start of T3 every line takes a fresh value from the word. A start request gives the first word index and says whether the access is a read or a write. Words then follow at consecutive indices until a word marked as last has finished.

The fourth line has two roles, set by a mode input. In output mode it is driven like the other three lines. In wait mode its output driver is switched off, and an external wait input is watched instead. In this mode two word bits pick the edge at which read data is captured, and decide whether the wait input may stall the program.

Bits in a control word are counted from the most significant end, so word bit k is vector bit 31-k.

Top module: `ctl_word_seq`

## Requirements
- R1: After reset, all four lines are high, the sample strobe is low and the done output is low.
- R2: When a start is accepted in idle, the word at the start index is read. Its T1 begins two cycles after the accepting edge. Each word lasts exactly four cycles unless it is frozen. Later words come from consecutive indices, wrapping modulo the array size.
- R3: Line n (n = 1, 2, 3) shows word bit 10+2n (vector bit 21-2n) during T1 and T2. It shows word bit 11+2n (vector bit 20-2n) during T3 and T4.
- R4: In output mode (mode input 0), the enable for line 4 is high. Line 4 shows word bit 18 (vector bit 13) during T1–T2 and word bit 19 (vector bit 12) during T3–T4.
- R5: In wait mode (mode input 1), the enable for line 4 is low and line 4 is held high.
- R6: During a read sequence the sample strobe is high for exactly one cycle per word. That cycle is the T3 cycle when in wait mode with word bit 18 set. Otherwise it is the T1 cycle. The strobe never rises during a write sequence.
- R7: In wait mode with word bit 19 set, a wait input that is high through a two-stage synchronizer at T1 freezes the word in T2. While frozen, every output holds. If the wait input is first sampled low at edge e, T3 starts at the third edge after e.
- R8: A high wait input has no effect when word bit 19 is clear or when in output mode.
- R9: A word with word bit 31 (vector bit 0) set is the last word. At the end of its T4 all lines go high, done is high for one cycle, and the block returns to idle.
- R10: A start request that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; four cycles make one word |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to start a sequence |
| start_idx_i | input | AW | Index of the first word |
| start_rd_i | input | 1 | 1 for a read sequence, 0 for a write |
| wait_mode_i | input | 1 | 0: line 4 is an output; 1: line 4 is the wait input |
| mem_addr_o | output | AW | Word-array read address |
| mem_data_i | input | 32 | Word-array read data, one cycle after the address |
| line_o | output | 4 | Strobe lines 1 to 4 (bit 0 is line 1) |
| line4_oe_o | output | 1 | Output enable for line 4 |
| wait_i | input | 1 | External wait input, asynchronous |
| sample_o | output | 1 | One-cycle data-sample strobe |
| done_o | output | 1 | One-cycle pulse after the last word |

## Verification
All 256 values of the eight line bits are swept in output and wait mode, for both reads and writes. The programs vary in length from one to four words, and their start indices wrap past the end of the array. This separates the T1 bit from the T3 bit of each line, tells the two roles of the fourth line apart, and checks the sample edge against the access type. Separate runs hold the wait input high with several release delays, and also with the enable bit clear or in output mode. These runs show whether the freeze length follows the release cycle exactly and whether the freeze is correctly gated. A start pulse in the middle of a run shows whether a busy sequence can be disturbed.

// File: rtl/ctl_word_seq.sv
module ctl_word_seq #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_idx_i,
  input  logic          start_rd_i,
  input  logic          wait_mode_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_data_i,
  output logic [3:0]    line_o,
  output logic          line4_oe_o,
  input  logic          wait_i,
  output logic          sample_o,
  output logic          done_o
);
  localparam int FHI = 19;
  localparam int FLO = 12;

  typedef enum logic [1:0] {S_IDLE, S_PRIME, S_LOAD, S_RUN} st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [AW-1:0] addr_q;
  logic [7:0]    fld_q;
  logic          last_q, rd_q, frz_q, done_q;
  logic [3:0]    line_q;
  logic [1:0]    wsync;

  logic [7:0] fld_in;
  logic       wait_s, late_edge, wait_en;
  logic       unused_bits;

  assign fld_in      = mem_data_i[FHI:FLO];
  assign unused_bits = ^{mem_data_i[31:FHI+1], mem_data_i[FLO-1:1]};
  assign wait_s      = wsync[1];
  assign late_edge   = wait_mode_i & fld_q[1];
  assign wait_en     = wait_mode_i & fld_q[0];

  function automatic logic [3:0] pick(input logic [7:0] f, input logic late, input logic wm);
    logic [3:0] r;
    for (int n = 0; n < 3; n++) r[n] = late ? f[6-2*n] : f[7-2*n];
    r[3] = wm | (late ? f[0] : f[1]);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) wsync <= '0;
    else        wsync <= {wsync[0], wait_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= '0;
      addr_q <= '0;
      fld_q  <= '0;
      last_q <= 1'b0;
      rd_q   <= 1'b0;
      frz_q  <= 1'b0;
      done_q <= 1'b0;
      line_q <= 4'hF;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          addr_q <= start_idx_i;
          rd_q   <= start_rd_i;
          st     <= S_PRIME;
        end
        S_PRIME: st <= S_LOAD;
        S_LOAD: begin
          fld_q  <= fld_in;
          last_q <= mem_data_i[0];
          addr_q <= addr_q + 1'b1;
          ph     <= 2'd0;
          frz_q  <= 1'b0;
          line_q <= pick(fld_in, 1'b0, wait_mode_i);
          st     <= S_RUN;
        end
        default: begin
          if (frz_q) begin
            if (!wait_s) frz_q <= 1'b0;
          end else begin
            case (ph)
              2'd0: begin
                ph <= 2'd1;
                if (wait_en && wait_s) frz_q <= 1'b1;
              end
              2'd1: begin
                ph     <= 2'd2;
                line_q <= pick(fld_q, 1'b1, wait_mode_i);
              end
              2'd2: ph <= 2'd3;
              default: begin
                ph <= 2'd0;
                if (last_q) begin
                  st     <= S_IDLE;
                  line_q <= 4'hF;
                  done_q <= 1'b1;
                end else begin
                  fld_q  <= fld_in;
                  last_q <= mem_data_i[0];
                  addr_q <= addr_q + 1'b1;
                  line_q <= pick(fld_in, 1'b0, wait_mode_i);
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assign mem_addr_o = addr_q;
  assign line_o     = line_q;
  assign line4_oe_o = ~wait_mode_i;
  assign done_o     = done_q;
  assign sample_o   = (st == S_RUN) && rd_q && (ph == {late_edge, 1'b0});
endmodule

// File: rtl/ctl_word_seq_chk.sv
module ctl_word_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wait_mode,
  input logic [3:0] line,
  input logic       sample,
  input logic       done,
  input logic       frz,
  input logic [1:0] ph
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (line == 4'hF));
  a_r6_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample);
  a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    frz |=> ($stable(line) && $stable(ph)));
  a_r5_line4_high: assert property (@(posedge clk) disable iff (!rst_n)
    wait_mode |-> line[3]);
  a_r3_change_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line) |-> (ph == 2'd0 || ph == 2'd2));
endmodule

bind ctl_word_seq ctl_word_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode_i), .line(line_o),
  .sample(sample_o), .done(done_o), .frz(frz_q), .ph(ph)
);

// File: tb/ctl_word_seq_test.sv
module ctl_word_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, srd = 1'b0, wmode = 1'b0, wait_in = 1'b0;
  logic [AW-1:0] sidx = '0, maddr;
  logic [31:0] mdata = '0;
  logic [3:0] line;
  logic oe, samp, done;
  logic [31:0] mem [DEPTH];
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) mdata <= mem[maddr];

  ctl_word_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_idx_i(sidx),
    .start_rd_i(srd), .wait_mode_i(wmode), .mem_addr_o(maddr),
    .mem_data_i(mdata), .line_o(line), .line4_oe_o(oe), .wait_i(wait_in),
    .sample_o(samp), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int f, input bit last, input int salt);
    logic [31:0] x = 32'(salt) * 32'h9E3779B1;
    return (x & 32'hFFF00FFE) | (32'(f & 255) << 12) | 32'(last);
  endfunction

  function automatic logic [3:0] exp_lines(input logic [31:0] w, input bit late, input bit m);
    logic [3:0] r;
    for (int n = 0; n < 3; n++) r[n] = w[19 - 2*n - int'(late)];
    r[3] = m ? 1'b1 : w[13 - int'(late)];
    return r;
  endfunction

  int fld [4];

  task automatic run_seq(input int idx, input int n, input bit rd, input bit m,
                         input bit hold, input int rel, input bit restart);
    logic [3:0] el [64];
    bit es [64];
    logic [31:0] w;
    int t, tend, extra;
    bit froze = 0;
    string tl;
    for (int k = 0; k < n; k++)
      mem[(idx + k) % DEPTH] = mk(fld[k], k == n - 1, idx * 8 + k + nchk);
    for (int k = 0; k < 2; k++) begin el[k] = 4'hF; es[k] = 0; end
    t = 2;
    for (int k = 0; k < n; k++) begin
      w = mem[(idx + k) % DEPTH];
      extra = (k == 0 && hold && m && w[12]) ? rel + 2 : 0;
      if (extra > 0) froze = 1;
      el[t] = exp_lines(w, 0, m); es[t] = rd && !(m && w[13]); t++;
      for (int j = 0; j < 1 + extra; j++) begin el[t] = exp_lines(w, 0, m); es[t] = 0; t++; end
      el[t] = exp_lines(w, 1, m); es[t] = rd && m && w[13]; t++;
      el[t] = exp_lines(w, 1, m); es[t] = 0; t++;
    end
    tend = t;
    el[tend] = 4'hF; es[tend] = 0;
    el[tend+1] = 4'hF; es[tend+1] = 0;
    tl = restart ? "R10" : froze ? "R7" : hold ? "R8" : "R3";
    @(negedge clk);
    wmode = m; wait_in = hold;
    repeat (3) @(negedge clk);
    start = 1; sidx = AW'(idx); srd = rd;
    for (int i = 0; i <= tend + 1; i++) begin
      @(negedge clk);
      if (i == 0) start = 0;
      if (restart && i == 5) start = 0;
      check(line[2:0] == el[i][2:0], (i >= tend) ? "R9" : tl, line, el[i]);
      check(line[3] == el[i][3], (i >= tend) ? "R9" : (m ? "R5" : "R4"), line, el[i]);
      check(oe == !m, m ? "R5" : "R4", oe, !m);
      check(samp == es[i], "R6", samp, es[i]);
      check(done == (i == tend), "R9", done, i == tend);
      if (restart && i == 4) begin start = 1; sidx = AW'(idx ^ 5); srd = !rd; end
      if (hold && i == 2 + rel) wait_in = 0;
    end
    wait_in = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R2 watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int f, r, len;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(line == 4'hF, "R1", line, 4'hF);
    check(samp == 0, "R1", samp, 0);
    check(done == 0, "R1", done, 0);

    // R2 R3 R4 R5 R6 R9: sweep every field value in all mode/access combinations
    for (int combo = 0; combo < 4; combo++) begin
      f = 0; r = 0;
      while (f < 256) begin
        len = 1 + (r % 4);
        for (int k = 0; k < len; k++) fld[k] = (f + k) & 255;
        run_seq((r * 7 + 61) % DEPTH, len, combo[0], combo[1], 0, 0, 0);
        f += len; r++;
      end
    end

    // R7: freeze with several release delays
    fld[0] = 8'hA7; fld[1] = 8'h5A; fld[2] = 8'hC3;
    run_seq(10, 3, 1, 1, 1, 1, 0);
    fld[0] = 8'h3D; fld[1] = 8'hFF; fld[2] = 8'h00;
    run_seq(62, 3, 0, 1, 1, 2, 0);
    fld[0] = 8'hC5; fld[1] = 8'h0E;
    run_seq(20, 2, 1, 1, 1, 5, 0);
    // R8: wait high but not enabled, and in output mode
    fld[0] = 8'hA6; fld[1] = 8'h55;
    run_seq(30, 2, 1, 1, 1, 1, 0);
    fld[0] = 8'h5B; fld[1] = 8'hE1;
    run_seq(40, 2, 1, 0, 1, 1, 0);
    // R10: start while busy
    fld[0] = 8'h96; fld[1] = 8'h69; fld[2] = 8'hF0; fld[3] = 8'h0F;
    run_seq(50, 4, 1, 0, 0, 0, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule